// File: doc/BRIEF.md
# Read-Capture Delay Training Sequencer

This block tunes the read-capture delay of a single byte lane of a DDR interface without software in the loop. After a start pulse it forces the delay tap to zero. It then reads a fixed eight-byte training pattern back through a simple request/acknowledge read port, one byte at a time. Before every read it pulses the PHY read FIFO into reset and waits a settle time.

The search runs in two phases. The first phase climbs the tap until a complete eight-byte pass succeeds, and records that tap as the lower edge of the passing window. The second phase keeps re-reading and climbing while passes succeed, and stops at the first failing byte. The tap is then set to the midpoint between the recorded lower edge and the failing tap, and the result is reported as ok. If the search would have to step beyond the highest tap, it reports an error.

A byte read fails when its data differs from the expected pattern byte, or when the bus flags the returned data as masked or dummy. The busy, done and result outputs give the surrounding boot logic a plain handshake.

Top module: `dqs_train_seq`

## Requirements
- R1: While reset is active, and after its release until the first start, busy_o, done_o, ok_o, err_o, rd_req_o and fifo_rst_o are 0 and tap_o is 0. A start accepted while idle raises busy_o on the next clock edge, clears tap_o to 0 on that same edge, and captures lane_i.
- R2: The pattern bytes, in read order 0 to 7, are FE, 11, 33, 55, 77, 99, BB, DD (hex). Byte k is read from address k*4 + lane.
- R3: Every read request is preceded by a one-cycle fifo_rst_o strobe. rd_req_o rises no earlier than SETTLE cycles after that strobe cycle.
- R4: A byte read fails if rd_data_i differs from the expected byte, or if rd_masked_i or rd_dummy_i is 1. All three are sampled in the cycle where rd_ack_i is 1.
- R5: In the first phase, a failing byte increments the tap by one and restarts the pass at byte 0. A full eight-byte pass records the current tap as the window start, and the second phase then begins at that same tap.
- R6: In the second phase, a full eight-byte pass increments the tap by one and restarts at byte 0. The first failing byte ends the phase.
- R7: When either phase needs an increment while the tap is 31, training ends with err_o=1, ok_o=0 and tap_o left at 31. The tap never wraps.
- R8: At the end of a successful second phase, one further fifo_rst_o strobe is issued in the cycle before done_o. tap_o becomes start + ((fail_tap - start) >> 1), and ok_o=1.
- R9: done_o is a one-cycle pulse in the same cycle that busy_o falls. ok_o, err_o and tap_o then stay stable until the next accepted start.
- R10: start_i is ignored while busy_o is 1. The lane and the tap of the run in progress are unaffected.
- R11: Once raised, rd_req_o stays high with a stable address until a cycle in which rd_ack_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a training run (taken only when idle) |
| lane_i | input | LANE_W | Byte lane to train |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Last run found and centred a window |
| err_o | output | 1 | Last run ran out of taps |
| tap_o | output | TAP_W | Read-capture delay tap to the PHY |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Byte read address |
| rd_ack_i | input | 1 | Read acknowledge, data and flags valid |
| rd_data_i | input | 8 | Returned byte |
| rd_masked_i | input | 1 | Returned data was masked |
| rd_dummy_i | input | 1 | Returned data was dummy fill |
| fifo_rst_o | output | 1 | One-cycle PHY read FIFO reset strobe |

## Verification
Two functions can land on one acknowledge. When the last byte of a second-phase pass succeeds while the tap is already 31, the increment decision and the top-of-range error coincide. The bench provokes this with windows that reach tap 31, and requires an error with the tap held at 31 and no wrap to 0.

Two functions also share the closing cycle: the final FIFO strobe and the centring both occur in the cycle before done. The bench records whether the strobe came one cycle ahead of done, and compares the centred tap with the midpoint it computes from the programmed window. A third collision is a start pulse arriving mid-run carrying a different lane. The lane-aware memory stub would turn an accepted restart into a wrong result, so the unchanged final tap shows that the start was rejected.

// File: rtl/dqs_train_pkg.sv
package dqs_train_pkg;

  localparam int PAT_LEN = 8;
  localparam int IDX_W   = $clog2(PAT_LEN);

  typedef enum logic [2:0] {
    S_IDLE,
    S_FRST,
    S_WAIT,
    S_REQ,
    S_FINAL
  } seq_state_t;

  // Training pattern, indexed by byte position within a pass
  function automatic logic [7:0] train_byte(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    train_byte = 8'hFE;
      3'd1:    train_byte = 8'h11;
      3'd2:    train_byte = 8'h33;
      3'd3:    train_byte = 8'h55;
      3'd4:    train_byte = 8'h77;
      3'd5:    train_byte = 8'h99;
      3'd6:    train_byte = 8'hBB;
      default: train_byte = 8'hDD;
    endcase
  endfunction

endpackage

// File: rtl/dqs_settle_timer.sv
module dqs_settle_timer #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= CNT_W'(SETTLE);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);

  // R3: a freshly loaded timer is never reported as expired on the next cycle
  a_r3_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);

endmodule

// File: rtl/dqs_byte_judge.sv
module dqs_byte_judge
  import dqs_train_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       rd_data,
  input  logic             masked,
  input  logic             dummy,
  output logic             fail
);
  logic [7:0] expect_byte;

  always_comb begin
    expect_byte = train_byte(idx);
    fail        = (rd_data != expect_byte) | masked | dummy;
  end

endmodule

// File: rtl/dqs_tap_ctr.sv
module dqs_tap_ctr #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             mark,
  input  logic             centre,
  output logic [TAP_W-1:0] tap,
  output logic             at_top
);
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] start_q;

  // Midpoint between the recorded lower edge and the first failing tap
  function automatic logic [TAP_W-1:0] mid_tap(input logic [TAP_W-1:0] lo,
                                               input logic [TAP_W-1:0] hi);
    mid_tap = lo + ((hi - lo) >> 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q   <= '0;
      start_q <= '0;
    end else begin
      if (clr)         tap_q <= '0;
      else if (inc)    tap_q <= tap_q + TAP_W'(1);
      else if (centre) tap_q <= mid_tap(start_q, tap_q);
      if (mark)        start_q <= tap_q;
    end
  end

  assign tap    = tap_q;
  assign at_top = &tap_q;

  // R7: the sequencer never asks for a step past the highest tap
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_top);

  // R8: centring lands inside the window, never below its lower edge
  a_r8_centre_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    centre |=> (tap_q >= start_q));

endmodule

// File: rtl/dqs_train_seq.sv
module dqs_train_seq
  import dqs_train_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int LANE_W     = 2,
  parameter int ADDR_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int SETTLE     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              err_o,
  output logic [TAP_W-1:0]  tap_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_masked_i,
  input  logic              rd_dummy_i,
  output logic              fifo_rst_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_LEN - 1);

  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LANE_W-1:0] lane_q;
  logic              phase_past_q;
  logic              busy_q, done_q, ok_q, err_q;

  // Named internal events
  logic tmr_load, tmr_expired;
  logic byte_fail, last_byte, ack_evt;
  logic tap_clr, tap_inc, tap_mark, tap_centre, tap_at_top;

  dqs_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(tmr_expired)
  );

  dqs_byte_judge u_judge (
    .idx(idx_q), .rd_data(rd_data_i), .masked(rd_masked_i),
    .dummy(rd_dummy_i), .fail(byte_fail)
  );

  dqs_tap_ctr #(.TAP_W(TAP_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .clr(tap_clr), .inc(tap_inc),
    .mark(tap_mark), .centre(tap_centre), .tap(tap_o), .at_top(tap_at_top)
  );

  assign ack_evt   = (state_q == S_REQ) && rd_ack_i;
  assign last_byte = (idx_q == LAST_IDX);
  assign tmr_load  = (state_q == S_FRST);

  always_comb begin
    tap_clr    = (state_q == S_IDLE) && start_i;
    tap_inc    = 1'b0;
    tap_mark   = 1'b0;
    tap_centre = (state_q == S_FINAL);
    if (ack_evt) begin
      if (!phase_past_q) begin
        tap_inc  = byte_fail && !tap_at_top;
        tap_mark = !byte_fail && last_byte;
      end else begin
        tap_inc  = !byte_fail && last_byte && !tap_at_top;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      idx_q        <= '0;
      lane_q       <= '0;
      phase_past_q <= 1'b0;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      ok_q         <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          busy_q       <= 1'b1;
          ok_q         <= 1'b0;
          err_q        <= 1'b0;
          lane_q       <= lane_i;
          idx_q        <= '0;
          phase_past_q <= 1'b0;
          state_q      <= S_FRST;
        end
        S_FRST: state_q <= S_WAIT;
        S_WAIT: if (tmr_expired) state_q <= S_REQ;
        S_REQ: if (rd_ack_i) begin
          if (!phase_past_q) begin
            if (byte_fail) begin
              if (tap_at_top) begin
                busy_q <= 1'b0; done_q <= 1'b1; err_q <= 1'b1; state_q <= S_IDLE;
              end else begin
                idx_q <= '0; state_q <= S_FRST;
              end
            end else if (last_byte) begin
              phase_past_q <= 1'b1; idx_q <= '0; state_q <= S_FRST;
            end else begin
              idx_q <= idx_q + IDX_W'(1); state_q <= S_FRST;
            end
          end else begin
            if (byte_fail) begin
              state_q <= S_FINAL;
            end else if (last_byte) begin
              if (tap_at_top) begin
                busy_q <= 1'b0; done_q <= 1'b1; err_q <= 1'b1; state_q <= S_IDLE;
              end else begin
                idx_q <= '0; state_q <= S_FRST;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1); state_q <= S_FRST;
            end
          end
        end
        S_FINAL: begin
          busy_q <= 1'b0; done_q <= 1'b1; ok_q <= 1'b1; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign err_o      = err_q;
  assign rd_req_o   = (state_q == S_REQ);
  assign rd_addr_o  = ADDR_W'(idx_q) * ADDR_W'(WORD_BYTES) + ADDR_W'(lane_q);
  assign fifo_rst_o = (state_q == S_FRST) || (state_q == S_FINAL);

  // R1: a run always begins at tap 0
  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (tap_o == '0) && !done_o);

  // R3: a request only follows an expired settle interval
  a_r3_req_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_o) |-> $past(tmr_expired));

  // R5 / R6: during a run the tap only moves upward by one
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (tap_o != $past(tap_o))) |-> (tap_o == $past(tap_o) + TAP_W'(1)));

  // R7: an error result leaves the tap at its top value
  a_r7_err_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (&tap_o));

  // R8: a successful finish follows the closing FIFO strobe
  a_r8_final_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ok_o) |-> $past(fifo_rst_o));

  // R9: done is a single-cycle pulse with exactly one result flag
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && (ok_o ^ err_o));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(tap_o) && $stable(ok_o) && $stable(err_o));

  // R11: a pending request and its address hold until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o && $stable(rd_addr_o));

endmodule

// File: tb/tb_dqs_train_seq.sv
`timescale 1ns/1ps
module tb_dqs_train_seq;
  localparam int TAP_W = 5, LANE_W = 2, ADDR_W = 8, SETTLE = 3;
  localparam logic [7:0] PAT [8] = '{8'hFE, 8'h11, 8'h33, 8'h55, 8'h77, 8'h99, 8'hBB, 8'hDD};

  typedef struct packed {
    logic [4:0] lo;
    logic [4:0] hi;
    logic [1:0] mode;    // 0 data corrupt, 1 masked flag, 2 dummy flag
    logic [3:0] fb;      // failing byte outside window, 8 = every byte
    logic [1:0] lane;
    logic       exp_ok;
    logic [4:0] exp_tap;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd5,  5'd12, 2'd0, 4'd8, 2'd0, 1'b1, 5'd9 },
    '{5'd0,  5'd7,  2'd1, 4'd8, 2'd1, 1'b1, 5'd4 },
    '{5'd10, 5'd10, 2'd2, 4'd8, 2'd2, 1'b1, 5'd10},
    '{5'd3,  5'd20, 2'd0, 4'd7, 2'd3, 1'b1, 5'd12},
    '{5'd30, 5'd30, 2'd0, 4'd8, 2'd1, 1'b1, 5'd30},
    '{5'd20, 5'd31, 2'd0, 4'd8, 2'd0, 1'b0, 5'd31},
    '{5'd31, 5'd31, 2'd1, 4'd8, 2'd2, 1'b0, 5'd31},
    '{5'd31, 5'd0,  2'd0, 4'd8, 2'd3, 1'b0, 5'd31},
    '{5'd0,  5'd31, 2'd2, 4'd8, 2'd1, 1'b0, 5'd31},
    '{5'd1,  5'd4,  2'd1, 4'd0, 2'd0, 1'b1, 5'd3 },
    '{5'd15, 5'd30, 2'd0, 4'd8, 2'd2, 1'b1, 5'd23}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [LANE_W-1:0] lane_i = '0;
  logic busy_o, done_o, ok_o, err_o, rd_req_o, fifo_rst_o;
  logic [TAP_W-1:0] tap_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic rd_ack_i = 1'b0, rd_masked_i = 1'b0, rd_dummy_i = 1'b0;
  logic [7:0] rd_data_i = '0;

  int checks = 0, failures = 0;
  vec_t cur = '0;
  int proto_err = 0, gap = 0;
  logic rst_seen = 1'b0, prev_frst = 1'b0;

  always #2.5 clk = ~clk;

  dqs_train_seq #(.TAP_W(TAP_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .WORD_BYTES(4), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane_i(lane_i),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .err_o(err_o), .tap_o(tap_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .rd_masked_i(rd_masked_i), .rd_dummy_i(rd_dummy_i),
    .fifo_rst_o(fifo_rst_o)
  );

  // Memory stub: correct pattern only inside [lo,hi] and only for the run's lane
  always @(posedge clk) begin
    prev_frst <= fifo_rst_o;
    if (fifo_rst_o) begin
      rst_seen <= 1'b1;
      gap      <= 0;
    end else begin
      gap <= gap + 1;
    end
    if (rd_req_o && !rd_ack_i) begin
      logic [4:0] bi;
      logic bad;
      bi  = 5'(rd_addr_o >> 2);
      bad = (rd_addr_o[1:0] != cur.lane) || (bi > 5'd7) ||
            (!((tap_o >= cur.lo) && (tap_o <= cur.hi)) &&
             ((cur.fb == 4'd8) || (cur.fb == 4'(bi))));
      if (!rst_seen || gap < SETTLE) proto_err <= proto_err + 1;
      rst_seen    <= 1'b0;
      rd_ack_i    <= 1'b1;
      rd_data_i   <= (bad && cur.mode == 2'd0) ? (PAT[bi[2:0]] ^ 8'h5A) : PAT[bi[2:0]];
      rd_masked_i <= bad && cur.mode == 2'd1;
      rd_dummy_i  <= bad && cur.mode == 2'd2;
    end else begin
      rd_ack_i    <= 1'b0;
      rd_masked_i <= 1'b0;
      rd_dummy_i  <= 1'b0;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int cyc;
    bit poked;
    poked = 1'b0;
    cur = v;
    proto_err = 0;
    @(negedge clk);
    lane_i  = v.lane;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
    chk(tap_o == '0, "R1 tap cleared at start", int'(tap_o), 0);
    cyc = 0;
    while (!done_o && cyc < 20000) begin
      if (poke && !poked && tap_o == 5'd3) begin
        lane_i  = ~v.lane;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        poked   = 1'b1;
        chk(busy_o && tap_o >= 5'd3, "R10 start ignored while busy", int'(tap_o), 3);
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    chk(done_o == 1'b1, "R9 done reached", int'(done_o), 1);
    chk(busy_o == 1'b0, "R9 busy low with done", int'(busy_o), 0);
    chk(ok_o == v.exp_ok && err_o == !v.exp_ok, "R7/R8 result flag", int'(ok_o), int'(v.exp_ok));
    chk(tap_o == v.exp_tap, v.exp_ok ? "R8 centred tap" : "R7 tap held at top", int'(tap_o), int'(v.exp_tap));
    chk(proto_err == 0, "R3 strobe and settle before each read", proto_err, 0);
    if (v.exp_ok) chk(prev_frst == 1'b1, "R8 closing FIFO strobe", int'(prev_frst), 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single cycle", int'(done_o), 0);
    repeat (4) @(negedge clk);
    chk(tap_o == v.exp_tap && ok_o == v.exp_ok, "R9 result held", int'(tap_o), int'(v.exp_tap));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !ok_o && !err_o, "R1 reset outputs", int'(busy_o), 0);
    chk(tap_o == '0 && !rd_req_o && !fifo_rst_o, "R1 reset tap and strobes", int'(tap_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && tap_o == '0 && !rd_req_o, "R1 idle after reset", int'(busy_o), 0);
    // Table walk: R2 lanes/pattern, R4 flag modes, R5/R6 phases, R7/R8 edges
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    // R10: start pulse with another lane mid-run
    run_vec(VECS[0], 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule